// File: doc/BRIEF.md
# Single-Page Write-Back EEPROM Cache

This block sits between a client and a byte-wide serial memory sequencer. It keeps one 256-byte page of the device in local RAM. Along with the page it holds a tag naming which page is present and a dirty flag. Client reads and writes are served from the buffer whenever the addressed page is resident.

When a different page is addressed, the buffer is first written back to the device if it holds modified bytes. The new page is then fetched, and the tag is updated. A flush request forces the write-back of a modified page without evicting it.

A separate pair of configuration operations addresses the highest page of the device. A configuration write is committed to the device within the same operation rather than deferred. Requests that fall outside the data area are refused with an error flag. Only one operation is in flight at a time.

Top module: `eepc_page_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` and `dev_req` are 0, and no page is resident, so the first access fetches a page without any write-back.
- R2: The page number is `req_addr[23:8]` and the byte offset within the page is `req_addr[7:0]`. A read of a resident page returns the byte at that offset with no device traffic.
- R3: A write (op code 1) to the resident page stores `req_wdata` in the buffer and marks it dirty. It causes no device traffic, and a later read returns the new byte.
- R4: An access to a non-resident page while the buffer is clean makes 256 device reads of that page, at offsets 0 to 255 in ascending order, and no device writes.
- R5: An access to a non-resident page while the buffer is dirty first writes the 256 buffered bytes back to the resident page in ascending order. It then fetches the new page as in R4.
- R6: `dev_req` stays high, with `dev_addr`, `dev_we` and `dev_wdata` unchanged, until a cycle in which `dev_ack` is high. Read data is taken from `dev_rdata` in that cycle.
- R7: A flush (op code 2) writes the page back only when it is dirty, and then clears the dirty flag while the page stays resident. On a clean buffer, the flush completes with no device traffic.
- R8: A configuration read (op code 3) addresses page NUM_PAGES-1 at offset `req_addr[7:0]` and ignores the upper address bits.
- R9: A configuration write (op code 4) fetches the last page if needed and updates the byte. It then writes the page back before completing, which leaves the buffer clean.
- R10: A read or write whose address is at or above (NUM_PAGES-1)*256 is rejected, and so are op codes 5 to 7. A rejected request completes one cycle after acceptance with `rsp_err` set, causes no device traffic and leaves the cached page and dirty flag unchanged.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low until completion, and completion is a one-cycle `rsp_done` pulse seen while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block idle, request may be accepted |
| req_op | input | 3 | 0 read, 1 write, 2 flush, 3 config read, 4 config write |
| req_addr | input | ADDR_W | Byte address (offset only for config ops) |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request was rejected (valid with rsp_done) |
| rsp_rdata | output | 8 | Read byte (valid with rsp_done) |
| dev_req | output | 1 | Device byte transfer request |
| dev_we | output | 1 | 1 write, 0 read |
| dev_addr | output | ADDR_W | Device byte address |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_ack | input | 1 | Device completes the transfer this cycle |
| dev_rdata | input | 8 | Byte returned by the device with dev_ack |

## Verification
The bench targets the transition from a dirty page to a new one. A design that fetched before writing back, or that wrote back to the new tag, would corrupt the device, and this shows up as a mismatch in the ordered transfer stream. It also checks that a flush on a clean buffer and a write hit produce no traffic, since a design that ignored the dirty flag would emit 256 needless writes. Rejected requests at the exact data-area limit are interleaved with dirty state, so that an off-by-one limit or a reject that clears the dirty flag gets caught later. Configuration writes are checked for immediate commit, and for a fetch of the last page when another dirty page is resident.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_FLUSH  = 3'd2,
    OP_CFG_RD = 3'd3,
    OP_CFG_WR = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WB_RD,
    ST_WB_LOAD,
    ST_WB_XFER,
    ST_FILL,
    ST_APPLY,
    ST_RD_LAT
  } state_e;
endpackage

// File: rtl/eepc_page_ram.sv
module eepc_page_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/eepc_addr_decode.sv
module eepc_addr_decode
  import eepc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int OFF_W     = 8,
  parameter int NUM_PAGES = 512
) (
  input  logic [2:0]              op,
  input  logic [ADDR_W-1:0]       addr,
  output logic [ADDR_W-OFF_W-1:0] page,
  output logic [OFF_W-1:0]        offset,
  output logic                    bad
);
  localparam int TAG_W      = ADDR_W - OFF_W;
  localparam int DATA_BYTES = (NUM_PAGES - 1) * (1 << OFF_W);
  localparam logic [TAG_W-1:0] CFG_PAGE = TAG_W'(NUM_PAGES - 1);

  logic is_cfg, is_data, past_end;

  always_comb begin
    is_cfg   = (op == OP_CFG_RD) || (op == OP_CFG_WR);
    is_data  = (op == OP_READ) || (op == OP_WRITE);
    past_end = {1'b0, addr} >= (ADDR_W+1)'(DATA_BYTES);
    page     = is_cfg ? CFG_PAGE : addr[ADDR_W-1:OFF_W];
    offset   = addr[OFF_W-1:0];
    bad      = (is_data && past_end) || (op > 3'd4);
  end
endmodule

// File: rtl/eepc_ctrl.sv
module eepc_ctrl
  import eepc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 8,
  parameter int DW     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic [DW-1:0]           req_wdata,
  input  logic [ADDR_W-OFF_W-1:0] dec_page,
  input  logic [OFF_W-1:0]        dec_offset,
  input  logic                    dec_bad,
  output logic                    rsp_done,
  output logic                    rsp_err,
  output logic [DW-1:0]           rsp_rdata,
  output logic                    dev_req,
  output logic                    dev_we,
  output logic [ADDR_W-1:0]       dev_addr,
  output logic [DW-1:0]           dev_wdata,
  input  logic                    dev_ack,
  input  logic [DW-1:0]           dev_rdata,
  output logic                    ram_we,
  output logic [OFF_W-1:0]        ram_addr,
  output logic [DW-1:0]           ram_wdata,
  input  logic [DW-1:0]           ram_rdata
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [TAG_W-1:0] TAG_EMPTY = '1;
  localparam logic [OFF_W-1:0] IDX_LAST  = '1;

  state_e           state;
  op_e              op_q;
  logic [TAG_W-1:0] page_q, tag_q;
  logic [OFF_W-1:0] off_q, idx_q;
  logic [DW-1:0]    wdata_q;
  logic             dirty_q, commit_q;

  logic is_wr_op, is_rd_op, miss;

  always_comb begin
    is_wr_op = (op_q == OP_WRITE) || (op_q == OP_CFG_WR);
    is_rd_op = (op_q == OP_READ)  || (op_q == OP_CFG_RD);
    miss     = (tag_q != page_q);
  end

  // Buffer port steering
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = off_q;
    ram_wdata = wdata_q;
    unique case (state)
      ST_FILL: begin
        ram_addr  = idx_q;
        ram_wdata = dev_rdata;
        ram_we    = dev_req && dev_ack;
      end
      ST_WB_RD: ram_addr = idx_q;
      ST_APPLY: ram_we   = is_wr_op;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_READ;
      page_q    <= '0;
      tag_q     <= TAG_EMPTY;
      off_q     <= '0;
      idx_q     <= '0;
      wdata_q   <= '0;
      dirty_q   <= 1'b0;
      commit_q  <= 1'b0;
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      dev_req   <= 1'b0;
      dev_we    <= 1'b0;
      dev_addr  <= '0;
      dev_wdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            if (dec_bad) begin
              rsp_done <= 1'b1;
              rsp_err  <= 1'b1;
            end else begin
              req_ready <= 1'b0;
              op_q      <= op_e'(req_op);
              page_q    <= dec_page;
              off_q     <= dec_offset;
              wdata_q   <= req_wdata;
              commit_q  <= 1'b0;
              state     <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (op_q == OP_FLUSH || commit_q) begin
            if (dirty_q) begin
              idx_q <= '0;
              state <= ST_WB_RD;
            end else begin
              rsp_done  <= 1'b1;
              rsp_err   <= 1'b0;
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end
          end else if (miss) begin
            idx_q <= '0;
            state <= dirty_q ? ST_WB_RD : ST_FILL;
          end else begin
            state <= ST_APPLY;
          end
        end
        ST_WB_RD: state <= ST_WB_LOAD;
        ST_WB_LOAD: begin
          dev_req   <= 1'b1;
          dev_we    <= 1'b1;
          dev_addr  <= {tag_q, idx_q};
          dev_wdata <= ram_rdata;
          state     <= ST_WB_XFER;
        end
        ST_WB_XFER: begin
          if (dev_ack) begin
            dev_req <= 1'b0;
            if (idx_q == IDX_LAST) begin
              dirty_q <= 1'b0;
              state   <= ST_CHECK;
            end else begin
              idx_q <= idx_q + 1'b1;
              state <= ST_WB_RD;
            end
          end
        end
        ST_FILL: begin
          if (!dev_req) begin
            dev_req  <= 1'b1;
            dev_we   <= 1'b0;
            dev_addr <= {page_q, idx_q};
          end else if (dev_ack) begin
            dev_req <= 1'b0;
            if (idx_q == IDX_LAST) begin
              tag_q <= page_q;
              state <= ST_CHECK;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_APPLY: begin
          if (is_rd_op) begin
            state <= ST_RD_LAT;
          end else begin
            dirty_q <= 1'b1;
            if (op_q == OP_CFG_WR) begin
              commit_q <= 1'b1;
              state    <= ST_CHECK;
            end else begin
              rsp_done  <= 1'b1;
              rsp_err   <= 1'b0;
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        ST_RD_LAT: begin
          rsp_rdata <= ram_rdata;
          rsp_done  <= 1'b1;
          rsp_err   <= 1'b0;
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eepc_page_cache.sv
module eepc_page_cache #(
  parameter int ADDR_W    = 24,
  parameter int OFF_W     = 8,
  parameter int NUM_PAGES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [7:0]        rsp_rdata,
  output logic              dev_req,
  output logic              dev_we,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [7:0]        dev_wdata,
  input  logic              dev_ack,
  input  logic [7:0]        dev_rdata
);
  localparam int DW    = 8;
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0] dec_page;
  logic [OFF_W-1:0] dec_offset;
  logic             dec_bad;
  logic             ram_we;
  logic [OFF_W-1:0] ram_addr;
  logic [DW-1:0]    ram_wdata, ram_rdata;

  eepc_addr_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_PAGES(NUM_PAGES)
  ) u_decode (
    .op(req_op), .addr(req_addr),
    .page(dec_page), .offset(dec_offset), .bad(dec_bad)
  );

  eepc_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DW(DW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata),
    .dec_page(dec_page), .dec_offset(dec_offset), .dec_bad(dec_bad),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  eepc_page_ram #(.AW(OFF_W), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );
endmodule

// File: rtl/eepc_page_cache_chk.sv
module eepc_page_cache_chk #(
  parameter int ADDR_W    = 24,
  parameter int OFF_W     = 8,
  parameter int NUM_PAGES = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              dev_req,
  input logic              dev_we,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [7:0]        dev_wdata,
  input logic              dev_ack
);
  localparam int LIMIT = (NUM_PAGES - 1) * (1 << OFF_W);

  logic accept_bad;
  always_comb
    accept_bad = req_valid && req_ready &&
                 ((req_op > 3'd4) ||
                  (req_op <= 3'd1 && {1'b0, req_addr} >= (ADDR_W+1)'(LIMIT)));

  a_r1_reset_idle: assert property (@(posedge clk)
    $fell(rst) |-> (req_ready && !dev_req && !rsp_done));

  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (dev_req && !dev_ack) |=>
      (dev_req && $stable(dev_addr) && $stable(dev_we) && $stable(dev_wdata)));

  a_r10_reject_next: assert property (@(posedge clk) disable iff (rst)
    accept_bad |=> (rsp_done && rsp_err && !dev_req));

  a_r11_done_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !dev_req);
endmodule

bind eepc_page_cache eepc_page_cache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_PAGES(NUM_PAGES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .rsp_done(rsp_done),
  .rsp_err(rsp_err), .dev_req(dev_req), .dev_we(dev_we),
  .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_ack(dev_ack)
);

// File: tb/eepc_page_cache_tb.sv
module eepc_page_cache_tb;
  localparam int ADDR_W = 24;
  localparam int OFF_W  = 8;
  localparam int NP     = 8;
  localparam int BYTES  = NP * 256;
  localparam int LIMIT  = (NP - 1) * 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_done, rsp_err;
  logic [7:0] rsp_rdata;
  logic dev_req, dev_we, dev_ack = 1'b0;
  logic [ADDR_W-1:0] dev_addr;
  logic [7:0] dev_wdata, dev_rdata = '0;

  always #10 clk = ~clk;

  eepc_page_cache #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_PAGES(NP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_rdata(dev_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cur_tag = "R1";

  // Device storage driven by the device model, and the reference model's copy
  logic [7:0] dmem [BYTES];
  logic [7:0] mdev [BYTES];
  logic [7:0] m_buf [256];
  int   m_tag = -1;
  bit   m_dirty = 1'b0;
  logic [32:0] expq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Device model: one-cycle acknowledge per request
  always @(posedge clk) begin
    if (rst) dev_ack <= 1'b0;
    else begin
      dev_ack <= dev_req && !dev_ack;
      if (dev_req && !dev_ack) begin
        if (dev_we) dmem[dev_addr] <= dev_wdata;
        else dev_rdata <= dmem[dev_addr];
      end
    end
  end

  // Every-clock comparison of device transfers against the model stream
  always @(negedge clk) begin
    if (!rst && dev_req && dev_ack) begin
      if (expq.size() == 0) begin
        chk(1'b0, {"R6/", cur_tag}, "unexpected transfer",
            {dev_we, dev_addr, dev_wdata}, 0);
      end else begin
        logic [32:0] e;
        e = expq.pop_front();
        chk(dev_we == e[32] && dev_addr == e[31:8] && (!e[32] || dev_wdata == e[7:0]),
            {"R6/", cur_tag}, "transfer", {dev_we, dev_addr, dev_wdata}, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic model_wb();
    for (int i = 0; i < 256; i++) begin
      expq.push_back({1'b1, 24'(m_tag * 256 + i), m_buf[i]});
      mdev[m_tag * 256 + i] = m_buf[i];
    end
    m_dirty = 1'b0;
  endtask

  task automatic model_fill(input int p);
    for (int i = 0; i < 256; i++) begin
      expq.push_back({1'b0, 24'(p * 256 + i), 8'h00});
      m_buf[i] = mdev[p * 256 + i];
    end
    m_tag = p;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [23:0] addr,
                       input logic [7:0] wd, input string tag);
    logic [7:0] erd;
    bit eerr;
    int p;
    cur_tag = tag;
    erd  = '0;
    eerr = (op > 3'd4) || (op <= 3'd1 && int'(addr) >= LIMIT);
    if (!eerr) begin
      if (op == 3'd2) begin
        if (m_dirty) model_wb();
      end else begin
        p = (op >= 3'd3) ? NP - 1 : int'(addr >> 8);
        if (p != m_tag) begin
          if (m_dirty) model_wb();
          model_fill(p);
        end
        if (op == 3'd0 || op == 3'd3) erd = m_buf[addr[7:0]];
        else begin
          m_buf[addr[7:0]] = wd;
          m_dirty = 1'b1;
          if (op == 3'd4) model_wb();
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    if (!eerr) chk(req_ready == 1'b0, "R11", "busy after accept", req_ready, 0);
    while (!rsp_done) @(negedge clk);
    chk(rsp_err == eerr, tag, "error flag", rsp_err, eerr);
    if (!eerr && (op == 3'd0 || op == 3'd3))
      chk(rsp_rdata == erd, tag, "read data", rsp_rdata, erd);
    chk(expq.size() == 0, tag, "transfers left over", expq.size(), 0);
    chk(req_ready == 1'b1, "R11", "ready with done", req_ready, 1);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R11", "done is one pulse", rsp_done, 0);
  endtask

  initial begin
    for (int i = 0; i < BYTES; i++) begin
      dmem[i] = 8'((i * 13 + 7) & 255);
      mdev[i] = 8'((i * 13 + 7) & 255);
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_done == 1'b0 && dev_req == 1'b0, "R1",
        "reset outputs", {req_ready, rsp_done, dev_req}, 3'b100);

    do_op(3'd0, 24'h000105, 8'h00, "R1");   // empty: fill only
    do_op(3'd0, 24'h0001FF, 8'h00, "R2");   // hit
    do_op(3'd1, 24'h000110, 8'hA5, "R3");   // write hit
    do_op(3'd0, 24'h000110, 8'h00, "R3");   // read back
    do_op(3'd0, 24'h000200, 8'h00, "R5");   // dirty miss
    do_op(3'd0, 24'h000110, 8'h00, "R4");   // clean miss, sees committed byte
    do_op(3'd2, 24'h000000, 8'h00, "R7");   // clean flush
    do_op(3'd1, 24'h000133, 8'h5C, "R3");
    do_op(3'd2, 24'h000000, 8'h00, "R7");   // dirty flush
    do_op(3'd2, 24'h000000, 8'h00, "R7");   // now clean
    do_op(3'd0, 24'h000133, 8'h00, "R7");   // page kept resident
    do_op(3'd0, 24'h0006FF, 8'h00, "R10");  // last legal byte
    do_op(3'd1, 24'h000600, 8'h11, "R3");
    do_op(3'd0, 24'h000700, 8'h00, "R10");  // first illegal byte
    do_op(3'd1, 24'hFFFFFF, 8'h22, "R10");
    do_op(3'd5, 24'h000000, 8'h00, "R10");  // undefined op
    do_op(3'd0, 24'h000600, 8'h00, "R10");  // state unchanged after rejects
    do_op(3'd2, 24'h000000, 8'h00, "R10");  // dirty survived rejects
    do_op(3'd3, 24'hABCD20, 8'h00, "R8");   // config read, upper bits ignored
    do_op(3'd4, 24'h000021, 8'h77, "R9");   // config write hit, commits now
    do_op(3'd2, 24'h000000, 8'h00, "R9");   // nothing left dirty
    do_op(3'd1, 24'h000300, 8'h3C, "R5");
    do_op(3'd4, 24'h123400, 8'h99, "R9");   // evict dirty page, fill, commit
    do_op(3'd3, 24'h000021, 8'h00, "R8");
    do_op(3'd0, 24'h000300, 8'h00, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule